// File: doc/BRIEF.md
# Driver Fault Protection Supervisor

This block watches the digitized fault flags of a multi-bridge motor driver and decides whether the output stages may be on. The flags come from analog sense circuits: one current-limit flag per bridge, an over-temperature flag and an undervoltage flag. The block turns them into one global driver enable, a step-indexer reset and three status bits that show which fault class is holding the drivers off.

Each fault class recovers in its own way. A current-limit condition on any bridge is first qualified by a deglitch counter. If it lasts long enough, it latches a shutdown of every bridge. Over-temperature shuts the drivers down at once and latches. Both latched faults clear only through the power-on reset input, which stands in for cycling the supply. Undervoltage holds the drivers off and the indexer in reset only while it lasts, then lets go by itself.

Every raw flag passes through a two-flop synchronizer before any decision uses it. After power-on reset the enable stays low for one extra clock, so the synchronizers can fill with valid samples.

Top module: `fault_supervisor`

## Requirements
- R1: The overcurrent latch sets when the OR of all bridge current-limit flags is sampled high on OC_LIMIT consecutive rising edges, on any mix of bridges. A run of fewer samples never sets it, because any edge with every flag low clears the qualification count.
- R2: Once the overcurrent latch is set, `drv_en` is low for every bridge and `stat_oc` is high. The latch becomes visible two edges after the last qualifying raw sample.
- R3: The overcurrent latch and `stat_oc` stay set after all current-limit flags drop. They clear only when `rst_n` is low.
- R4: A raw over-temperature flag drops `drv_en` on the second rising edge after it is first sampled, and `stat_ot` rises one edge later.
- R5: The over-temperature latch keeps `drv_en` low and `stat_ot` high after the flag clears, until `rst_n` is low.
- R6: While the synchronized undervoltage flag is high, `drv_en` is low and `stat_uv` is high. Both recover without reset two edges after the raw flag clears.
- R7: `idx_rst` is high while synchronized undervoltage is active, during reset, and until the enable is armed.
- R8: `drv_en` and all status bits are low while `rst_n` is low. `drv_en` stays low through the first rising edge with `rst_n` high and rises after the second, when no fault is present.
- R9: A change on any raw fault input reaches the outputs no earlier than the second rising edge after it is applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low power-on reset; the only way to clear latched faults |
| ilim_raw | input | NUM_BRIDGES | Asynchronous current-limit flags, one per bridge |
| otemp_raw | input | 1 | Asynchronous over-temperature flag |
| uvolt_raw | input | 1 | Asynchronous undervoltage flag |
| drv_en | output | 1 | Global enable for all bridges |
| idx_rst | output | 1 | Reset to the step indexer |
| stat_oc | output | 1 | Overcurrent shutdown latched |
| stat_ot | output | 1 | Over-temperature shutdown latched |
| stat_uv | output | 1 | Undervoltage currently active |

## Verification
The assertions assume that the raw flags are stable around each clock edge, so the synchronizers pass them on in the cycle counts stated above. They also assume that `rst_n` is low from time zero. The bench keeps to both rules: it changes every input one time unit after a rising edge, and it starts with reset held. It sweeps each bridge's current-limit pulse over lengths from one sample to two past the deglitch count. It also tries pulses split across bridges and pulses broken by a one-edge gap, to test the qualification boundary.

// File: rtl/fs_pkg.sv
package fs_pkg;
    // Fault status reported to the outside: which class holds the drivers off.
    typedef struct packed {
        logic oc;   // overcurrent latched
        logic ot;   // over-temperature latched
        logic uv;   // undervoltage active
    } fs_status_t;

    // Number of reset-release edges before the enable may rise.
    localparam int unsigned ARM_EDGES = 2;
endpackage

// File: rtl/fs_sync.sv
// fs_sync: a synchronizer chain for a vector of asynchronous flags.
// Each bit has STAGES flops. The output is the last stage. The chain
// clears to zero on synchronous active-low reset. Assumes each bit is
// an independent level flag, with no coherence needed across bits.
module fs_sync #(
    parameter int unsigned WIDTH  = 4,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_raw,
    output logic [WIDTH-1:0] q_sync
);
    logic [WIDTH-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // First stage samples the raw asynchronous inputs.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[0] <= '0;
                    else        chain[0] <= d_raw;
                end
            end else begin : g_next
                // Later stages shift the previous stage along.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[s] <= '0;
                    else        chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/fs_oc_qual.sv
// fs_oc_qual: deglitch and latch for the current-limit flags.
// Counts the consecutive cycles in which any synchronized flag is high.
// Reaching LIMIT cycles sets a sticky latch that clears only on reset.
// Any cycle with every flag low clears the count. Assumes LIMIT >= 2.
module fs_oc_qual #(
    parameter int unsigned NUM_BRIDGES = 4,
    parameter int unsigned LIMIT       = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_BRIDGES-1:0] ilim_s,
    output logic                   oc_latched
);
    localparam int unsigned CW = (LIMIT > 2) ? $clog2(LIMIT) : 1;
    localparam logic [CW-1:0] TERM = CW'(LIMIT - 1);

    logic          any_lim;
    logic [CW-1:0] cnt_q;
    logic          oc_q;

    assign any_lim = |ilim_s;

    // Qualification counter: runs while any flag is high, else clears.
    always_ff @(posedge clk) begin
        if (!rst_n)                         cnt_q <= '0;
        else if (!any_lim)                  cnt_q <= '0;
        else if (cnt_q != TERM)             cnt_q <= cnt_q + 1'b1;
    end

    // Sticky overcurrent latch: sets on the LIMIT-th consecutive sample.
    always_ff @(posedge clk) begin
        if (!rst_n)                         oc_q <= 1'b0;
        else if (any_lim && cnt_q == TERM)  oc_q <= 1'b1;
    end

    assign oc_latched = oc_q;

    // R1: counter never passes its terminal value
    p_cnt_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= TERM);
    // R1: a new latch needs a flag seen high on the previous sample
    p_oc_cause_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(oc_q) |-> $past(any_lim));
    // R3: latch is sticky while out of reset
    p_oc_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        oc_q |=> oc_q);
endmodule

// File: rtl/fs_core.sv
// fs_core: combines the fault classes into the enable and indexer reset.
// Latches over-temperature until reset and passes undervoltage through
// without a latch. Arms the enable ARM_EDGES edges after reset release,
// so the synchronizers hold valid samples before drivers may turn on.
module fs_core
    import fs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       oc_latched,
    input  logic       ot_s,
    input  logic       uv_s,
    output logic       drv_en,
    output logic       idx_rst,
    output fs_status_t status
);
    logic [ARM_EDGES-1:0] arm_q;
    logic                 armed;
    logic                 ot_q;

    // Arming shift register: fills with ones after reset release.
    always_ff @(posedge clk) begin
        if (!rst_n) arm_q <= '0;
        else        arm_q <= {arm_q[ARM_EDGES-2:0], 1'b1};
    end

    assign armed = arm_q[ARM_EDGES-1];

    // Thermal latch: set by the synchronized flag, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)    ot_q <= 1'b0;
        else if (ot_s) ot_q <= 1'b1;
    end

    // Enable: armed and free of every fault. Live thermal acts at once.
    always_comb begin
        drv_en  = armed && !oc_latched && !ot_q && !ot_s && !uv_s;
        idx_rst = !armed || uv_s;
        status  = '{oc: oc_latched, ot: ot_q, uv: uv_s};
    end

    // R5: thermal latch is sticky while out of reset
    p_ot_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ot_q |=> ot_q);
    // R4: a synchronized thermal flag is latched on the next edge
    p_ot_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ot_s |=> ot_q);
endmodule

// File: rtl/fault_supervisor.sv
// fault_supervisor: top of the driver fault protection supervisor.
// Synchronizes the raw flags, qualifies overcurrent, latches thermal
// faults, passes undervoltage through, and drives one global enable
// and an indexer reset. Assumes rst_n is low from power-up.
module fault_supervisor
    import fs_pkg::*;
#(
    parameter int unsigned NUM_BRIDGES = 4,
    parameter int unsigned OC_LIMIT    = 4,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_BRIDGES-1:0] ilim_raw,
    input  logic                   otemp_raw,
    input  logic                   uvolt_raw,
    output logic                   drv_en,
    output logic                   idx_rst,
    output logic                   stat_oc,
    output logic                   stat_ot,
    output logic                   stat_uv
);
    localparam int unsigned SW = NUM_BRIDGES + 2;

    logic [SW-1:0]          raw_all;
    logic [SW-1:0]          sync_all;
    logic [NUM_BRIDGES-1:0] ilim_s;
    logic                   ot_s;
    logic                   uv_s;
    logic                   oc_latched;
    fs_status_t             status;

    assign raw_all = {uvolt_raw, otemp_raw, ilim_raw};
    assign ilim_s  = sync_all[NUM_BRIDGES-1:0];
    assign ot_s    = sync_all[NUM_BRIDGES];
    assign uv_s    = sync_all[NUM_BRIDGES+1];

    fs_sync #(.WIDTH(SW), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .d_raw  (raw_all),
        .q_sync (sync_all)
    );

    fs_oc_qual #(.NUM_BRIDGES(NUM_BRIDGES), .LIMIT(OC_LIMIT)) u_oc (
        .clk        (clk),
        .rst_n      (rst_n),
        .ilim_s     (ilim_s),
        .oc_latched (oc_latched)
    );

    fs_core u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .oc_latched (oc_latched),
        .ot_s       (ot_s),
        .uv_s       (uv_s),
        .drv_en     (drv_en),
        .idx_rst    (idx_rst),
        .status     (status)
    );

    assign stat_oc = status.oc;
    assign stat_ot = status.ot;
    assign stat_uv = status.uv;

    // R2: a latched overcurrent keeps every driver off
    p_oc_blocks_en_r2: assert property (@(posedge clk) disable iff (!rst_n)
        oc_latched |-> !drv_en);
    // R6: active undervoltage keeps drivers off
    p_uv_blocks_en_r6: assert property (@(posedge clk) disable iff (!rst_n)
        uv_s |-> !drv_en);
    // R7: active undervoltage holds the indexer in reset
    p_uv_idx_r7: assert property (@(posedge clk) disable iff (!rst_n)
        uv_s |-> idx_rst);
    // R8: first edge out of reset never enables the drivers
    p_en_after_rst_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> !drv_en);
endmodule

// File: tb/sim_fault_supervisor.sv
module sim_fault_supervisor;
    localparam int CLK_PERIOD = 10;
    localparam int NB  = 4;
    localparam int LIM = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NB-1:0] ilim_raw = '0;
    logic          otemp_raw = 1'b0;
    logic          uvolt_raw = 1'b0;
    logic          drv_en, idx_rst, stat_oc, stat_ot, stat_uv;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fault_supervisor #(.NUM_BRIDGES(NB), .OC_LIMIT(LIM), .SYNC_STAGES(2)) u0 (
        .clk(clk), .rst_n(rst_n), .ilim_raw(ilim_raw), .otemp_raw(otemp_raw),
        .uvolt_raw(uvolt_raw), .drv_en(drv_en), .idx_rst(idx_rst),
        .stat_oc(stat_oc), .stat_ot(stat_ot), .stat_uv(stat_uv)
    );

    // Advance n rising edges, then settle one unit after the edge.
    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    // Power-on reset with all flags low.
    task automatic por();
        ilim_raw = '0; otemp_raw = 1'b0; uvolt_raw = 1'b0;
        rst_n = 1'b0;
        tick(2);
        rst_n = 1'b1;
        tick(2);
    endtask

    initial begin
        // R8: reset state and arming delay
        tick(2);
        chk("R8", "drv_en in reset", drv_en, 1'b0);
        chk("R8", "stat_oc in reset", stat_oc, 1'b0);
        chk("R8", "stat_ot in reset", stat_ot, 1'b0);
        chk("R8", "stat_uv in reset", stat_uv, 1'b0);
        chk("R7", "idx_rst in reset", idx_rst, 1'b1);
        rst_n = 1'b1;
        tick(1);
        chk("R8", "drv_en after 1st edge", drv_en, 1'b0);
        chk("R7", "idx_rst before armed", idx_rst, 1'b1);
        tick(1);
        chk("R8", "drv_en after 2nd edge", drv_en, 1'b1);
        chk("R7", "idx_rst armed", idx_rst, 1'b0);

        // R1/R2: sweep every bridge and pulse length 1..LIM+2
        for (int b = 0; b < NB; b++) begin
            for (int d = 1; d <= LIM + 2; d++) begin
                por();
                ilim_raw[b] = 1'b1;
                tick(d);
                ilim_raw = '0;
                tick(2);
                chk("R1", $sformatf("stat_oc bridge %0d len %0d", b, d), stat_oc, (d >= LIM));
                chk("R2", $sformatf("drv_en bridge %0d len %0d", b, d), drv_en, (d < LIM));
            end
        end

        // R2: exact latch timing, two edges after the last qualifying sample
        por();
        ilim_raw[1] = 1'b1;
        tick(LIM + 1);
        chk("R2", "stat_oc one edge early", stat_oc, 1'b0);
        chk("R2", "drv_en one edge early", drv_en, 1'b1);
        tick(1);
        chk("R2", "stat_oc at latch edge", stat_oc, 1'b1);
        chk("R2", "drv_en at latch edge", drv_en, 1'b0);
        // R3: sticky after flags drop, cleared by reset
        ilim_raw = '0;
        tick(6);
        chk("R3", "stat_oc held", stat_oc, 1'b1);
        chk("R3", "drv_en held low", drv_en, 1'b0);
        por();
        chk("R3", "stat_oc cleared by reset", stat_oc, 1'b0);
        chk("R3", "drv_en back after reset", drv_en, 1'b1);

        // R1: run spread across bridges still qualifies
        por();
        ilim_raw[0] = 1'b1;
        tick(2);
        ilim_raw[2] = 1'b1;
        tick(1);
        ilim_raw[0] = 1'b0;
        tick(LIM - 3);
        ilim_raw = '0;
        tick(3);
        chk("R1", "mixed-bridge run latches", stat_oc, 1'b1);

        // R1: a one-edge gap clears the count
        por();
        ilim_raw[3] = 1'b1;
        tick(LIM - 1);
        ilim_raw = '0;
        tick(1);
        ilim_raw[3] = 1'b1;
        tick(LIM - 1);
        ilim_raw = '0;
        tick(3);
        chk("R1", "gapped runs do not latch", stat_oc, 1'b0);
        chk("R1", "drv_en stays high after gapped runs", drv_en, 1'b1);

        // R4/R5/R9: over-temperature timing and latch
        por();
        otemp_raw = 1'b1;
        tick(1);
        chk("R9", "drv_en unaffected one edge after OT", drv_en, 1'b1);
        tick(1);
        chk("R4", "drv_en off two edges after OT", drv_en, 1'b0);
        chk("R4", "stat_ot not yet", stat_ot, 1'b0);
        tick(1);
        chk("R4", "stat_ot set", stat_ot, 1'b1);
        otemp_raw = 1'b0;
        tick(6);
        chk("R5", "stat_ot held after flag clears", stat_ot, 1'b1);
        chk("R5", "drv_en held low after flag clears", drv_en, 1'b0);
        por();
        chk("R5", "stat_ot cleared by reset", stat_ot, 1'b0);
        chk("R5", "drv_en back after reset", drv_en, 1'b1);

        // R6/R7/R9: undervoltage with self recovery
        por();
        uvolt_raw = 1'b1;
        tick(1);
        chk("R9", "stat_uv not yet", stat_uv, 1'b0);
        chk("R9", "drv_en high one edge after UV", drv_en, 1'b1);
        tick(1);
        chk("R6", "stat_uv active", stat_uv, 1'b1);
        chk("R6", "drv_en off under UV", drv_en, 1'b0);
        chk("R7", "idx_rst under UV", idx_rst, 1'b1);
        tick(5);
        chk("R6", "drv_en still off under long UV", drv_en, 1'b0);
        uvolt_raw = 1'b0;
        tick(1);
        chk("R9", "drv_en still off one edge after UV clears", drv_en, 1'b0);
        tick(1);
        chk("R6", "drv_en recovers", drv_en, 1'b1);
        chk("R6", "stat_uv clears", stat_uv, 1'b0);
        chk("R7", "idx_rst released", idx_rst, 1'b0);

        // R7/R8: UV present across reset release keeps the enable off
        rst_n = 1'b0;
        uvolt_raw = 1'b1;
        tick(2);
        rst_n = 1'b1;
        tick(2);
        chk("R8", "drv_en off with UV at reset exit", drv_en, 1'b0);
        chk("R7", "idx_rst with UV at reset exit", idx_rst, 1'b1);
        uvolt_raw = 1'b0;
        tick(2);
        chk("R6", "drv_en up after UV at reset exit", drv_en, 1'b1);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                total++;
                bad++;
                $display("FAIL watchdog: actual=timeout expected=completion");
            end
        join_any
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule